// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns single transfer requests from a processor core into the pin-level timing of a minimum-mode bus. Address and data share one set of lines. A request is a read, a write or an interrupt acknowledge. Each request carries a memory/IO qualifier, an address and, for a write, the data to be written. The sequencer runs the clock states T1, T2, T3, optional wait states, and T4. It produces the address strobe, the read, write and acknowledge strobes, the transceiver enable and direction lines, and the memory/IO select. It drives the shared lines through an output enable and hands read data back with a one-cycle completion strobe.

Wait states come from a ready input that is sampled at the end of T3 and of every wait state. Another bus master takes the bus with a hold request. The sequencer grants it only at a cycle boundary: it raises the acknowledge and releases every line it drives, then takes the bus back when the hold request drops. An interrupt acknowledge always runs as two back-to-back cycles. The vector byte is taken from the data lines in the second cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the block is idle: `ale_o` low, `rd_no`, `wr_no`, `den_no` and `inta_no` high, `hlda_o` and `done_o` low, `ctl_oe_o` high, `req_ready_o` high.
- R2: In T1, `ale_o` is high for exactly one clock and `den_no` is high. `ad_o` carries the full request address. `dtr_o` is 1 for a write and 0 otherwise. `mio_o` equals the memory qualifier for reads and writes and is 0 for an interrupt acknowledge. `ad_oe_o` is high.
- R3: From T2 through the last wait state `den_no` is low. The top AW-DW lines of `ad_o` carry status {zeros, ack, write, mem}, with bit 0 as mem, bit 1 as write and bit 2 as ack, up to and including T4. At most one of `rd_no`, `wr_no` and `inta_no` is low at any time.
- R4: A read (`req_op_i` = 2'b00, and 2'b11 is treated the same) drives `rd_no` low from T2 through the last wait state. `ad_oe_o` is low from T2 through T4. `rdata_o` takes `ad_i` as sampled at the clock edge that ends the last T3/Tw and shows it from T4 on.
- R5: A write (`req_op_i` = 2'b01) drives `wr_no` low from T2 through the last wait state. It keeps `ad_oe_o` high and puts the write data on the low DW lines of `ad_o` from T2 through T4.
- R6: In T4 all three strobes and `den_no` are high and `done_o` is high for that single clock. With no wait states a transfer takes exactly four clocks from T1 to T4.
- R7: Each clock edge at the end of T3 or Tw with `ready_i` low inserts one more wait state. A wait state shows the same outputs as T3, so N low samples lengthen the cycle by exactly N clocks.
- R8: `req_ready_o` is high only in the idle state or in a T4 that closes a transfer, and only with `hold_i` low. A request accepted in T4 starts T1 on the very next clock. Without a request the block idles.
- R9: `hold_i` is acted on only at an idle clock or the final T4, and never mid-cycle. On the next clock `hlda_o` is high and `ctl_oe_o`, `ad_oe_o` and `ale_o` are low. A request presented meanwhile is not accepted.
- R10: When `hold_i` is low during a hold clock, the next clock is idle with `hlda_o` low and `ctl_oe_o` high. A pending request is accepted from that idle clock.
- R11: An interrupt acknowledge (`req_op_i` = 2'b10) runs two consecutive cycles. Each cycle has `inta_no` low from T2 through the last wait state, `rd_no` high and `ad_oe_o` low. `done_o` is raised only in the second T4. `rdata_o` is the low VW bits of `ad_i` sampled in the second cycle, zero-extended.
- R12: A hold request raised during the first cycle of an interrupt acknowledge pair is granted only after the second cycle completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | A transfer request is present |
| req_op_i | input | 2 | 00 read, 01 write, 10 interrupt acknowledge, 11 read |
| req_mem_i | input | 1 | 1 memory space, 0 I/O space |
| req_addr_i | input | AW (20) | Transfer address |
| req_wdata_i | input | DW (16) | Write data |
| req_ready_o | output | 1 | Request is taken at this clock edge if valid |
| ready_i | input | 1 | Target ready; low inserts wait states |
| hold_i | input | 1 | Another master requests the bus |
| hlda_o | output | 1 | Bus granted to the other master |
| ale_o | output | 1 | Address latch strobe, high in T1 |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| den_no | output | 1 | Transceiver enable, active low |
| dtr_o | output | 1 | Transceiver direction, 1 transmit, 0 receive |
| mio_o | output | 1 | 1 memory, 0 I/O |
| inta_no | output | 1 | Interrupt acknowledge strobe, active low |
| ctl_oe_o | output | 1 | Enable for control lines and upper shared lines |
| ad_o | output | AW (20) | Value for the shared address/data/status lines |
| ad_oe_o | output | 1 | Enable for the low DW shared lines |
| ad_i | input | DW (16) | Value read from the low DW shared lines |
| rdata_o | output | DW (16) | Read data or vector byte of the last transfer |
| done_o | output | 1 | One-clock completion strobe in the final T4 |

## Verification
The hold handshake and the acceptance of a new transfer both act at the same cycle boundary. They can meet in one T4 clock. The bench raises the hold request in T2 of a write and then presents a read at that write's T4. It judges that the grant wins: the read is refused, the bus floats for the whole hold period, and the read starts from the idle clock after release. The second collision is a hold request that arrives inside the first half of an interrupt acknowledge pair. There the bench expects the second acknowledge cycle to follow at once, and the grant only after its T4.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5,
        ST_HOLD = 3'd6
    } bus_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_INTA  = 2'b10,
        OP_RSVD  = 2'b11
    } bus_op_e;

endpackage

// File: rtl/bcs_seq.sv
// State register and request latch of the bus cycle sequencer.
module bcs_seq
    import bcs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16,
    parameter int VW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_valid_i,
    input  logic [1:0]    req_op_i,
    input  logic          req_mem_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    input  logic          ready_i,
    input  logic          hold_i,
    input  logic [DW-1:0] ad_i,
    output logic          req_ready_o,
    output bus_state_e    state_o,
    output logic          wr_o,
    output logic          ia_o,
    output logic          sec_o,
    output logic          mem_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic [DW-1:0] rdata_o
);

    typedef struct packed {
        bus_state_e    st;
        logic          wr;
        logic          ia;
        logic          sec;
        logic          mem;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          boundary;
    logic          pair_open;
    logic          can_take;
    logic          take;
    logic [DW-1:0] cap_val;

    always_comb begin
        seq_d     = seq_q;
        boundary  = (seq_q.st == ST_IDLE) || (seq_q.st == ST_T4);
        pair_open = seq_q.ia && !seq_q.sec;
        can_take  = boundary && !pair_open && !hold_i;
        take      = can_take && req_valid_i;

        cap_val = ad_i;
        if (seq_q.ia) begin
            cap_val          = '0;
            cap_val[VW-1:0]  = ad_i[VW-1:0];
        end

        unique case (seq_q.st)
            ST_IDLE: begin
                if (hold_i) seq_d.st = ST_HOLD;
            end
            ST_T1: seq_d.st = ST_T2;
            ST_T2: seq_d.st = ST_T3;
            ST_T3, ST_TW: begin
                if (ready_i) begin
                    seq_d.st = ST_T4;
                    if (!seq_q.wr && (!seq_q.ia || seq_q.sec)) begin
                        seq_d.rdata = cap_val;
                    end
                end else begin
                    seq_d.st = ST_TW;
                end
            end
            ST_T4: begin
                if (pair_open) begin
                    seq_d.sec = 1'b1;
                    seq_d.st  = ST_T1;
                end else if (hold_i) begin
                    seq_d.st = ST_HOLD;
                end else begin
                    seq_d.st = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (!hold_i) seq_d.st = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase

        if (take) begin
            seq_d.st    = ST_T1;
            seq_d.wr    = (bus_op_e'(req_op_i) == OP_WRITE);
            seq_d.ia    = (bus_op_e'(req_op_i) == OP_INTA);
            seq_d.sec   = 1'b0;
            seq_d.mem   = req_mem_i && (bus_op_e'(req_op_i) != OP_INTA);
            seq_d.addr  = req_addr_i;
            seq_d.wdata = req_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready_o = can_take;
    assign state_o     = seq_q.st;
    assign wr_o        = seq_q.wr;
    assign ia_o        = seq_q.ia;
    assign sec_o       = seq_q.sec;
    assign mem_o       = seq_q.mem;
    assign addr_o      = seq_q.addr;
    assign wdata_o     = seq_q.wdata;
    assign rdata_o     = seq_q.rdata;

endmodule

// File: rtl/bcs_drive.sv
// Pin decode: turns the registered state into bus control levels.
module bcs_drive
    import bcs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  bus_state_e    state_i,
    input  logic          wr_i,
    input  logic          ia_i,
    input  logic          sec_i,
    input  logic          mem_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          hlda_o,
    output logic          ale_o,
    output logic          rd_no,
    output logic          wr_no,
    output logic          den_no,
    output logic          dtr_o,
    output logic          mio_o,
    output logic          inta_no,
    output logic          ctl_oe_o,
    output logic [AW-1:0] ad_o,
    output logic          ad_oe_o,
    output logic          done_o
);

    localparam int SW = AW - DW;

    logic          strobe;
    logic          data_phase;
    logic [SW-1:0] status;
    logic [DW-1:0] low_bits;

    always_comb begin
        strobe     = (state_i == ST_T2) || (state_i == ST_T3) || (state_i == ST_TW);
        data_phase = strobe || (state_i == ST_T4);
        status     = SW'({ia_i, wr_i, mem_i});
        low_bits   = wr_i ? wdata_i : {DW{1'b0}};

        hlda_o   = (state_i == ST_HOLD);
        ctl_oe_o = !hlda_o;
        ale_o    = (state_i == ST_T1);
        den_no   = !strobe;
        rd_no    = !(strobe && !wr_i && !ia_i);
        wr_no    = !(strobe && wr_i);
        inta_no  = !(strobe && ia_i);
        dtr_o    = wr_i;
        mio_o    = mem_i;
        ad_o     = data_phase ? {status, low_bits} : addr_i;
        ad_oe_o  = ctl_oe_o && !(data_phase && !wr_i);
        done_o   = (state_i == ST_T4) && !(ia_i && !sec_i);
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16,
    parameter int VW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_valid_i,
    input  logic [1:0]    req_op_i,
    input  logic          req_mem_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    output logic          req_ready_o,
    input  logic          ready_i,
    input  logic          hold_i,
    output logic          hlda_o,
    output logic          ale_o,
    output logic          rd_no,
    output logic          wr_no,
    output logic          den_no,
    output logic          dtr_o,
    output logic          mio_o,
    output logic          inta_no,
    output logic          ctl_oe_o,
    output logic [AW-1:0] ad_o,
    output logic          ad_oe_o,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] rdata_o,
    output logic          done_o
);

    bus_state_e    st;
    logic          cyc_wr;
    logic          cyc_ia;
    logic          cyc_sec;
    logic          cyc_mem;
    logic [AW-1:0] cyc_addr;
    logic [DW-1:0] cyc_wdata;

    bcs_seq #(.AW(AW), .DW(DW), .VW(VW)) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .req_op_i    (req_op_i),
        .req_mem_i   (req_mem_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .ready_i     (ready_i),
        .hold_i      (hold_i),
        .ad_i        (ad_i),
        .req_ready_o (req_ready_o),
        .state_o     (st),
        .wr_o        (cyc_wr),
        .ia_o        (cyc_ia),
        .sec_o       (cyc_sec),
        .mem_o       (cyc_mem),
        .addr_o      (cyc_addr),
        .wdata_o     (cyc_wdata),
        .rdata_o     (rdata_o)
    );

    bcs_drive #(.AW(AW), .DW(DW)) u_drive (
        .state_i  (st),
        .wr_i     (cyc_wr),
        .ia_i     (cyc_ia),
        .sec_i    (cyc_sec),
        .mem_i    (cyc_mem),
        .addr_i   (cyc_addr),
        .wdata_i  (cyc_wdata),
        .hlda_o   (hlda_o),
        .ale_o    (ale_o),
        .rd_no    (rd_no),
        .wr_no    (wr_no),
        .den_no   (den_no),
        .dtr_o    (dtr_o),
        .mio_o    (mio_o),
        .inta_no  (inta_no),
        .ctl_oe_o (ctl_oe_o),
        .ad_o     (ad_o),
        .ad_oe_o  (ad_oe_o),
        .done_o   (done_o)
    );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic ready_i,
    input logic hold_i,
    input logic req_ready_o,
    input logic hlda_o,
    input logic ale_o,
    input logic rd_no,
    input logic wr_no,
    input logic den_no,
    input logic inta_no,
    input logic ctl_oe_o,
    input logic ad_oe_o,
    input logic done_o
);

    assert_ale_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ale_o |=> !ale_o);

    assert_ale_den_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ale_o |-> den_no);

    assert_den_after_ale_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ale_o |=> !den_no);

    assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({!rd_no, !wr_no, !inta_no}));

    assert_read_float_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_no |-> !ad_oe_o);

    assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_rd_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_no && !ready_i) |=> !rd_no);

    assert_wr_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_no && !ready_i) |=> !wr_no);

    assert_no_take_in_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> !hlda_o);

    assert_hold_float_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hlda_o |-> (!ctl_oe_o && !ad_oe_o && !ale_o));

    assert_grant_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hlda_o) |-> $past(hold_i));

    assert_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hlda_o && !hold_i) |=> !hlda_o);

endmodule

bind bus_cycle_seq bcs_checker u_bcs_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ready_i     (ready_i),
    .hold_i      (hold_i),
    .req_ready_o (req_ready_o),
    .hlda_o      (hlda_o),
    .ale_o       (ale_o),
    .rd_no       (rd_no),
    .wr_no       (wr_no),
    .den_no      (den_no),
    .inta_no     (inta_no),
    .ctl_oe_o    (ctl_oe_o),
    .ad_oe_o     (ad_oe_o),
    .done_o      (done_o)
);

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;

    localparam int AW = 20;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_ni;
    logic          req_valid_i;
    logic [1:0]    req_op_i;
    logic          req_mem_i;
    logic [AW-1:0] req_addr_i;
    logic [DW-1:0] req_wdata_i;
    logic          req_ready_o;
    logic          ready_i;
    logic          hold_i;
    logic          hlda_o, ale_o, rd_no, wr_no, den_no, dtr_o, mio_o, inta_no;
    logic          ctl_oe_o, ad_oe_o, done_o;
    logic [AW-1:0] ad_o;
    logic [DW-1:0] ad_i;
    logic [DW-1:0] rdata_o;

    int checks = 0;
    int errors = 0;
    bit hold_mid = 1'b0;

    always #2 clk = ~clk;

    bus_cycle_seq dut (
        .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
        .req_mem_i(req_mem_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .req_ready_o(req_ready_o), .ready_i(ready_i), .hold_i(hold_i), .hlda_o(hlda_o),
        .ale_o(ale_o), .rd_no(rd_no), .wr_no(wr_no), .den_no(den_no), .dtr_o(dtr_o),
        .mio_o(mio_o), .inta_no(inta_no), .ctl_oe_o(ctl_oe_o), .ad_o(ad_o),
        .ad_oe_o(ad_oe_o), .ad_i(ad_i), .rdata_o(rdata_o), .done_o(done_o)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic present(input logic [1:0] op, input logic mem,
                           input logic [AW-1:0] addr, input logic [DW-1:0] wd);
        req_valid_i = 1'b1;
        req_op_i    = op;
        req_mem_i   = mem;
        req_addr_i  = addr;
        req_wdata_i = wd;
    endtask

    // Called at a negedge where the request is already presented and will be
    // taken at the next edge; returns at the negedge inside the final T4.
    task automatic run_cycle(input logic [1:0] op, input logic mem,
                             input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                             input int waits);
        bit            is_wr  = (op == 2'b01);
        bit            is_ia  = (op == 2'b10);
        logic          m_eff  = is_ia ? 1'b0 : mem;
        logic [3:0]    stat   = {1'b0, is_ia, is_wr, m_eff};
        logic [DW-1:0] rv     = addr[15:0] ^ 16'hA5C3;
        logic [7:0]    vec    = addr[7:0] ^ 8'h3C;
        int            ncyc   = is_ia ? 2 : 1;
        for (int c = 0; c < ncyc; c++) begin
            bit last = (c == ncyc - 1);
            @(negedge clk);
            if (c == 0) req_valid_i = 1'b0;
            ad_i = 16'hDEAD;
            check("R2 ale in T1", ale_o, 1'b1);
            check("R2 den_n in T1", den_no, 1'b1);
            check("R2 address in T1", ad_o, addr);
            check("R2 dtr in T1", dtr_o, is_wr);
            check("R2 mio in T1", mio_o, m_eff);
            check("R2 ad_oe in T1", ad_oe_o, 1'b1);
            check("R6 no done in T1", done_o, 1'b0);
            for (int p = 0; p < 2 + waits; p++) begin
                @(negedge clk);
                check("R3 den_n low", den_no, 1'b0);
                check("R3 status lines", ad_o[19:16], stat);
                check("R7 ale low in T2/T3/Tw", ale_o, 1'b0);
                check("R6 no done before T4", done_o, 1'b0);
                if (p == 0) check("R8 no accept mid-cycle", req_ready_o, 1'b0);
                if (is_wr) begin
                    check("R5 wr_n low", wr_no, 1'b0);
                    check("R5 write data", ad_o[15:0], wd);
                    check("R5 ad_oe high", ad_oe_o, 1'b1);
                end else if (is_ia) begin
                    check("R11 inta_n low", inta_no, 1'b0);
                    check("R11 rd_n high", rd_no, 1'b1);
                    check("R11 ad_oe low", ad_oe_o, 1'b0);
                end else begin
                    check("R4 rd_n low", rd_no, 1'b0);
                    check("R4 ad_oe low", ad_oe_o, 1'b0);
                end
                if (p == 0 && c == 0 && hold_mid) begin
                    hold_i   = 1'b1;
                    hold_mid = 1'b0;
                end
                if (p >= 1) begin
                    ready_i = (p == 1 + waits);
                    if (p == 1 + waits)
                        ad_i = is_ia ? {8'hEE, vec} : rv;
                end
            end
            @(negedge clk);
            ready_i = 1'b1;
            ad_i    = 16'hBEEF;
            check("R6 rd_n high in T4", rd_no, 1'b1);
            check("R6 wr_n high in T4", wr_no, 1'b1);
            check("R6 inta_n high in T4", inta_no, 1'b1);
            check("R6 den_n high in T4", den_no, 1'b1);
            check("R11 done only on final T4", done_o, last);
            if (is_wr) check("R5 write data in T4", ad_o[15:0], wd);
            else       check("R4 ad_oe low in T4", ad_oe_o, 1'b0);
            if (last && is_ia) check("R11 vector byte", rdata_o, {8'h00, vec});
            if (!is_wr && !is_ia) check("R4 read data", rdata_o, rv);
        end
    endtask

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_ni = 1'b0; req_valid_i = 1'b0; req_op_i = 2'b00; req_mem_i = 1'b0;
        req_addr_i = '0; req_wdata_i = '0; ready_i = 1'b1; hold_i = 1'b0; ad_i = '0;
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        check("R1 ale", ale_o, 1'b0);
        check("R1 rd_n", rd_no, 1'b1);
        check("R1 wr_n", wr_no, 1'b1);
        check("R1 den_n", den_no, 1'b1);
        check("R1 inta_n", inta_no, 1'b1);
        check("R1 hlda", hlda_o, 1'b0);
        check("R1 done", done_o, 1'b0);
        check("R1 ctl_oe", ctl_oe_o, 1'b1);
        check("R1 req_ready", req_ready_o, 1'b1);

        // Sweep: op x space x wait count; some back-to-back, some with idle gap.
        for (int idx = 0; idx < 16; idx++) begin
            logic [1:0]    op   = idx[0] ? 2'b01 : ((idx == 6) ? 2'b11 : 2'b00);
            logic          mem  = idx[1];
            int            wt   = idx[3:2];
            logic [AW-1:0] addr = AW'((idx + 1) * 32'h1B3A7) ^ 20'h50F0F;
            logic [DW-1:0] wd   = DW'(idx * 16'h1111) ^ 16'h5A0F;
            if (idx != 0 && (idx % 3) != 0) begin
                @(negedge clk);
                check("R8 idle ale", ale_o, 1'b0);
                check("R8 idle req_ready", req_ready_o, 1'b1);
                check("R8 idle done", done_o, 1'b0);
            end
            present(op, mem, addr, wd);
            if (idx != 0 && (idx % 3) == 0) begin
                #1;
                check("R8 accept in T4", req_ready_o, 1'b1);
            end
            run_cycle(op, mem, addr, wd, wt);
        end

        // Interrupt acknowledge with one wait state per cycle.
        @(negedge clk);
        present(2'b10, 1'b1, 20'h0_4C21, 16'h0);
        run_cycle(2'b10, 1'b1, 20'h0_4C21, 16'h0, 1);

        // R12: hold raised inside the first acknowledge cycle.
        @(negedge clk);
        present(2'b10, 1'b0, 20'h0_0097, 16'h0);
        hold_mid = 1'b1;
        run_cycle(2'b10, 1'b0, 20'h0_0097, 16'h0, 0);
        @(negedge clk);
        check("R12 grant after pair", hlda_o, 1'b1);
        hold_i = 1'b0;
        @(negedge clk);
        check("R10 release", hlda_o, 1'b0);

        // R9: hold raised mid-write, read presented at the same T4 boundary.
        present(2'b01, 1'b1, 20'hA_1234, 16'hC0DE);
        hold_mid = 1'b1;
        run_cycle(2'b01, 1'b1, 20'hA_1234, 16'hC0DE, 2);
        present(2'b00, 1'b1, 20'h3_3333, 16'h0);
        #1;
        check("R9 request refused under hold", req_ready_o, 1'b0);
        @(negedge clk);
        check("R9 hlda", hlda_o, 1'b1);
        check("R9 ctl_oe off", ctl_oe_o, 1'b0);
        check("R9 ad_oe off", ad_oe_o, 1'b0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R9 held", hlda_o, 1'b1);
            check("R9 no ale while held", ale_o, 1'b0);
            check("R9 no accept while held", req_ready_o, 1'b0);
        end
        hold_i = 1'b0;
        @(negedge clk);
        check("R10 hlda dropped", hlda_o, 1'b0);
        check("R10 ctl_oe back", ctl_oe_o, 1'b1);
        run_cycle(2'b00, 1'b1, 20'h3_3333, 16'h0, 0);

        // R9: hold from idle.
        @(negedge clk);
        hold_i = 1'b1;
        @(negedge clk);
        check("R9 grant from idle", hlda_o, 1'b1);
        hold_i = 1'b0;
        @(negedge clk);
        check("R10 release from idle", hlda_o, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule